// File: doc/BRIEF.md
# Burst Pause Attribution Monitor

This block is a passive observer on a pipelined system bus. Every clock it looks at the transfer type, the burst type, the address and the ready signal. It decides which end of the bus is to blame for each lost cycle. A cycle in which the initiator marks a pause inside an open burst is charged to the initiator. A cycle in which the target holds the ready signal low is charged to the target. The block also counts the bursts that run to completion.

Alongside the counting, it watches for misuse of the pause mechanism and raises sticky flags for four cases. The first is a pause issued while no burst is open. The second is a fixed-length burst cut short by an idle cycle and then followed by a new start; this is counted as abandonment. The third is a pause whose address differs from the beat that resumes the burst. The fourth is a run of pauses longer than the limit set on an input pin. Software reads the counters and flags through a small combinational register port and clears them with a single write.

Top module: `bus_pause_monitor`

## Requirements
- R1: Transfer type codes are 00 idle, 01 pause, 10 first beat, 11 continuation beat. Burst codes are 000 single, 001 open-ended, 010/011 four beats, 100/101 eight beats, 110/111 sixteen beats. Burst state advances only in cycles where `hready` is high.
- R2: Register 0 counts cycles in which the type is pause and `hready` is high.
- R3: Register 1 counts every cycle in which `hready` is low, whatever the transfer type.
- R4: An accepted first beat with a four-, eight- or sixteen-beat code opens a burst, and each accepted continuation beat adds a beat. When the beat count reaches the length, the burst closes and register 2 increments. A first beat with the open-ended code opens a burst that closes, and is counted, at the next accepted idle or first beat.
- R5: A pause in any cycle while no burst is open sets flag bit 0.
- R6: An accepted idle while a fixed-length burst still has beats outstanding closes that burst and arms an abandon mark. The next accepted first beat then sets flag bit 1, increments register 3 and disarms the mark.
- R7: Every cycle of type pause, with `hready` high or low, extends a run, and any other type ends it. Flag bit 3 is set in the cycle where the run length exceeds `busy_limit`.
- R8: The address of the most recent accepted pause is compared with the address of the next accepted continuation beat, and a mismatch sets flag bit 2. An accepted idle or first beat discards the held address.
- R9: `rd_data` shows, with no clock delay, register `reg_addr`: 0 to 3 are the counters and 4 is the flag vector in its low four bits. Every other address reads zero. A change appears on the clock edge that sees its cause.
- R10: Counters saturate at 2^CNT_W-1.
- R11: A write (`reg_wr` high) to address 7 clears all counters when `reg_wdata[0]` is set and all flags when `reg_wdata[1]` is set. A clear wins over an increment or a flag set in the same cycle. Otherwise flags stay set once set.
- R12: After reset all counters and flags are zero and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| htrans | input | 2 | Observed transfer type |
| hburst | input | 3 | Observed burst type |
| haddr | input | AW | Observed address |
| hready | input | 1 | Observed ready |
| busy_limit | input | LW | Longest allowed run of pause cycles |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for read and write |
| reg_wdata | input | 2 | Clear bits: [0] counters, [1] flags |
| rd_data | output | CNT_W | Selected register contents |

## Verification
The embedded properties assume that the observed bus changes only between clock edges. They also assume that `busy_limit` and the register-port inputs are stable for a whole cycle, and they make no assumption about whether the bus traffic is legal. The stimulus drives every input a fixed time after the edge. It holds `busy_limit` constant, issues writes only with a full-cycle strobe, and deliberately injects illegal traffic (stray pauses, cut-short bursts, shifted held addresses and long pause runs) so that every flag path is exercised.

// File: rtl/bmon_pkg.sv
`timescale 1ns/1ps
package bmon_pkg;
  localparam logic [1:0] TR_IDLE = 2'b00;
  localparam logic [1:0] TR_WAIT = 2'b01;
  localparam logic [1:0] TR_NEW  = 2'b10;
  localparam logic [1:0] TR_NEXT = 2'b11;
  localparam logic [2:0] BT_OPEN = 3'b001;
  localparam int         BEAT_W  = 5;

  function automatic logic [BEAT_W-1:0] burst_beats(input logic [2:0] bt);
    case (bt)
      3'b010, 3'b011: burst_beats = 5'd4;
      3'b100, 3'b101: burst_beats = 5'd8;
      3'b110, 3'b111: burst_beats = 5'd16;
      default:        burst_beats = 5'd1;
    endcase
  endfunction
endpackage

// File: rtl/bmon_sat_cnt.sv
`timescale 1ns/1ps
module bmon_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) q <= '0;
    else if (inc && q != TOP) q <= q + 1'b1;
  end

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q == TOP && !clr) |=> q == TOP);
endmodule

// File: rtl/bmon_run.sv
`timescale 1ns/1ps
module bmon_run #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_pause,
  input  logic [LW-1:0] limit,
  output logic          ev_long
);
  localparam logic [LW-1:0] RUN_TOP = '1;
  logic [LW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !is_pause) run_q <= '0;
    else if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
  end

  assign ev_long = is_pause && (run_q >= limit);

  // R7
  run_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_pause |=> run_q == '0);
endmodule

// File: rtl/bmon_track.sv
`timescale 1ns/1ps
module bmon_track
  import bmon_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    htrans,
  input  logic [2:0]    hburst,
  input  logic [AW-1:0] haddr,
  input  logic          hready,
  output logic          in_burst,
  output logic          ev_done,
  output logic          ev_abandon,
  output logic          ev_addr_bad
);
  logic                open_q, open_d, fixed_q, fixed_d, armed_q, armed_d;
  logic                held_q, held_d;
  logic [AW-1:0]       hadr_q, hadr_d;
  logic [BEAT_W-1:0]   rem_q, rem_d, beats;

  assign beats = burst_beats(hburst);

  always_comb begin
    open_d = open_q; fixed_d = fixed_q; armed_d = armed_q;
    held_d = held_q; hadr_d = hadr_q; rem_d = rem_q;
    ev_done = 1'b0; ev_abandon = 1'b0; ev_addr_bad = 1'b0;
    if (hready) begin
      case (htrans)
        TR_IDLE: begin
          if (open_q && fixed_q) armed_d = 1'b1;
          else if (open_q) ev_done = 1'b1;
          open_d = 1'b0;
          held_d = 1'b0;
        end
        TR_NEW: begin
          if (open_q && !fixed_q) ev_done = 1'b1;
          if (armed_q) begin
            ev_abandon = 1'b1;
            armed_d = 1'b0;
          end
          held_d = 1'b0;
          if (hburst == BT_OPEN) begin
            open_d = 1'b1; fixed_d = 1'b0;
          end else if (beats > 5'd1) begin
            open_d = 1'b1; fixed_d = 1'b1; rem_d = beats - 5'd1;
          end else begin
            open_d = 1'b0;
          end
        end
        TR_NEXT: begin
          if (held_q && haddr != hadr_q) ev_addr_bad = 1'b1;
          held_d = 1'b0;
          if (open_q && fixed_q) begin
            rem_d = rem_q - 5'd1;
            if (rem_q == 5'd1) begin
              open_d = 1'b0; ev_done = 1'b1;
            end
          end
        end
        default: begin
          held_d = 1'b1;
          hadr_d = haddr;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0; fixed_q <= 1'b0; armed_q <= 1'b0;
      held_q <= 1'b0; hadr_q <= '0; rem_q <= '0;
    end else begin
      open_q <= open_d; fixed_q <= fixed_d; armed_q <= armed_d;
      held_q <= held_d; hadr_q <= hadr_d; rem_q <= rem_d;
    end
  end

  assign in_burst = open_q;

  // R4
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && fixed_q) |-> rem_q != '0);

  // R6
  armed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> (!open_q && $past(htrans) == TR_IDLE));
endmodule

// File: rtl/bus_pause_monitor.sv
`timescale 1ns/1ps
module bus_pause_monitor
  import bmon_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LW    = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       htrans,
  input  logic [2:0]       hburst,
  input  logic [AW-1:0]    haddr,
  input  logic             hready,
  input  logic [LW-1:0]    busy_limit,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [1:0]       reg_wdata,
  output logic [CNT_W-1:0] rd_data
);
  localparam int NCNT = 4;
  localparam int NFLG = 4;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic in_burst, ev_done, ev_abandon, ev_addr_bad, ev_long, is_pause;
  logic clr_c, clr_f;
  logic [NCNT-1:0]  cnt_inc;
  logic [CNT_W-1:0] cnt_q [NCNT];
  logic [NFLG-1:0]  flag_set, flags_q;

  assign is_pause = (htrans == TR_WAIT);
  assign clr_c    = reg_wr && reg_addr == 3'd7 && reg_wdata[0];
  assign clr_f    = reg_wr && reg_addr == 3'd7 && reg_wdata[1];

  bmon_track #(.AW(AW)) u_track (
    .clk(clk), .rst_n(rst_n), .htrans(htrans), .hburst(hburst),
    .haddr(haddr), .hready(hready), .in_burst(in_burst),
    .ev_done(ev_done), .ev_abandon(ev_abandon), .ev_addr_bad(ev_addr_bad));

  bmon_run #(.LW(LW)) u_run (
    .clk(clk), .rst_n(rst_n), .is_pause(is_pause),
    .limit(busy_limit), .ev_long(ev_long));

  assign cnt_inc  = {ev_abandon, ev_done, !hready, is_pause && hready};
  assign flag_set = {ev_long, ev_addr_bad, ev_abandon, is_pause && !in_burst};

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    bmon_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr_c), .inc(cnt_inc[i]), .q(cnt_q[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_f) flags_q <= '0;
    else flags_q <= flags_q | flag_set;
  end

  always_comb begin
    case (reg_addr)
      3'd0:    rd_data = cnt_q[0];
      3'd1:    rd_data = cnt_q[1];
      3'd2:    rd_data = cnt_q[2];
      3'd3:    rd_data = cnt_q[3];
      3'd4:    rd_data = CNT_W'(flags_q);
      default: rd_data = '0;
    endcase
  end

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_f |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R3
  wait_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hready && !clr_c && cnt_q[1] != CMAX) |=> cnt_q[1] == $past(cnt_q[1]) + 1'b1);

  // R5
  stray_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pause && !in_burst && !clr_f) |=> flags_q[0]);
endmodule

// File: tb/sim_bus_pause_monitor.sv
`timescale 1ns/1ps
module sim_bus_pause_monitor;
  localparam int AW = 8, LW = 8, CW = 4, LIMIT = 3;
  localparam int CMAXV = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic [1:0] htrans = 0;
  logic [2:0] hburst = 0;
  logic [AW-1:0] haddr = 0;
  logic hready = 1;
  logic [LW-1:0] busy_limit = LW'(LIMIT);
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [1:0] reg_wdata = 0;
  logic [CW-1:0] rd_data;

  int errors = 0, checks = 0;
  bit finished = 0;

  // reference model state
  int m_cnt [4];
  int m_flags, m_run, m_rem, m_helda;
  bit m_open, m_fixed, m_armed, m_heldv;

  always #2.5 clk = ~clk;

  bus_pause_monitor #(.AW(AW), .LW(LW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .htrans(htrans), .hburst(hburst), .haddr(haddr),
    .hready(hready), .busy_limit(busy_limit), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_data(rd_data));

  function automatic int beats(input int b);
    if (b < 2) return 1;
    return 4 << ((b - 2) / 2);
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = 3'(a);
    #0.1;
    v = int'(rd_data);
  endtask

  task automatic model_reset();
    foreach (m_cnt[i]) m_cnt[i] = 0;
    m_flags = 0; m_run = 0; m_rem = 0; m_helda = 0;
    m_open = 0; m_fixed = 0; m_armed = 0; m_heldv = 0;
  endtask

  task automatic model_step();
    int t, b, a, inc [4], setf;
    bit r, cc, cf;
    t = int'(htrans); b = int'(hburst); a = int'(haddr); r = hready;
    cc = reg_wr && reg_addr == 3'd7 && reg_wdata[0];
    cf = reg_wr && reg_addr == 3'd7 && reg_wdata[1];
    foreach (inc[i]) inc[i] = 0;
    setf = 0;
    if (t == 1 && !m_open) setf |= 1;
    if (t == 1 && m_run >= LIMIT) setf |= 8;
    if (t == 1) m_run = (m_run < 255) ? m_run + 1 : m_run; else m_run = 0;
    if (t == 1 && r) inc[0] = 1;
    if (!r) inc[1] = 1;
    if (r) begin
      if (t == 0) begin
        if (m_open && m_fixed) m_armed = 1;
        else if (m_open) inc[2] = 1;
        m_open = 0; m_heldv = 0;
      end else if (t == 2) begin
        if (m_open && !m_fixed) inc[2] = 1;
        if (m_armed) begin inc[3] = 1; setf |= 2; m_armed = 0; end
        m_heldv = 0;
        if (b == 1) begin m_open = 1; m_fixed = 0; end
        else if (beats(b) > 1) begin m_open = 1; m_fixed = 1; m_rem = beats(b); end
        else m_open = 0;
        if (m_open && m_fixed) m_rem = m_rem - 1;
      end else if (t == 3) begin
        if (m_heldv && a != m_helda) setf |= 4;
        m_heldv = 0;
        if (m_open && m_fixed) begin
          m_rem = m_rem - 1;
          if (m_rem == 0) begin m_open = 0; inc[2] = 1; end
        end
      end else begin
        m_heldv = 1; m_helda = a;
      end
    end
    for (int i = 0; i < 4; i++) begin
      if (cc) m_cnt[i] = 0;
      else if (inc[i] != 0 && m_cnt[i] < CMAXV) m_cnt[i]++;
    end
    if (cf) m_flags = 0; else m_flags |= setf;
  endtask

  task automatic compare_all();
    int v;
    rd(0, v); check("R2 pause count", v, m_cnt[0]);
    rd(1, v); check("R3 wait count", v, m_cnt[1]);
    rd(2, v); check("R4 burst count", v, m_cnt[2]);
    rd(3, v); check("R6 abandon count", v, m_cnt[3]);
    rd(4, v); check("flags R5 R6 R7 R8", v, m_flags);
  endtask

  task automatic step(input int t, input int b, input int a, input bit r,
                      input bit w, input int wd);
    htrans = 2'(t); hburst = 3'(b); haddr = AW'(a); hready = r;
    reg_wr = w; reg_wdata = 2'(wd); reg_addr = w ? 3'd7 : 3'd0;
    @(posedge clk);
    model_step();
    #1;
    reg_wr = 0;
    compare_all();
  endtask

  task automatic cyc(input int t, input int b, input int a, input bit r);
    step(t, b, a, r, 0, 0);
  endtask

  task automatic clr_all();
    step(0, 0, 0, 1, 1, 3);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R12 reset state
    for (int i = 0; i < 5; i++) begin rd(i, v); check("R12 reset zero", v, 0); end
    // R9 unmapped addresses read zero
    rd(5, v); check("R9 unmapped 5", v, 0);
    rd(7, v); check("R9 unmapped 7", v, 0);

    // R1 R4: four-beat burst completes
    cyc(2, 3, 0, 1); cyc(3, 3, 4, 1); cyc(3, 3, 8, 1); cyc(3, 3, 12, 1); cyc(0, 0, 0, 1);
    rd(2, v); check("R1 R4 four-beat done", v, 1);

    // R2 R3 R8: eight-beat with wait state and a correctly held pause
    clr_all();
    cyc(2, 5, 0, 1); cyc(3, 5, 4, 0); cyc(3, 5, 4, 1);
    cyc(1, 5, 64, 1); cyc(1, 5, 64, 1); cyc(3, 5, 64, 1);
    for (int i = 0; i < 5; i++) cyc(3, 5, 68 + 4 * i, 1);
    rd(0, v); check("R2 two pauses", v, 2);
    rd(1, v); check("R3 one wait", v, 1);
    rd(2, v); check("R4 eight-beat done", v, 1);
    rd(4, v); check("R8 held address ok", v, 0);

    // R5: pause with no open burst, also with hready low
    clr_all();
    cyc(0, 0, 0, 1); cyc(1, 0, 0, 0);
    rd(4, v); check("R5 stray pause flag", v, 1);
    rd(0, v); check("R2 pause with hready low not counted", v, 0);
    rd(1, v); check("R3 wait during pause", v, 1);

    // R6: cut-short burst then restart
    clr_all();
    cyc(2, 2, 0, 1); cyc(3, 2, 4, 1); cyc(0, 0, 0, 1);
    rd(3, v); check("R6 no abandon before restart", v, 0);
    cyc(0, 0, 0, 1); cyc(2, 0, 32, 1);
    rd(3, v); check("R6 abandon count", v, 1);
    rd(4, v); check("R6 abandon flag", v, 2);

    // R8: held address mismatch
    clr_all();
    cyc(2, 3, 0, 1); cyc(3, 3, 4, 1); cyc(1, 3, 8, 1); cyc(3, 3, 12, 1); cyc(3, 3, 16, 1);
    rd(4, v); check("R8 address mismatch flag", v, 4);
    rd(2, v); check("R4 burst still completes", v, 1);

    // R7: pause run longer than the limit
    clr_all();
    cyc(2, 7, 0, 1);
    for (int i = 0; i < LIMIT; i++) cyc(1, 7, 4, 1);
    rd(4, v); check("R7 run at limit no flag", v, 0);
    cyc(1, 7, 4, 1);
    rd(4, v); check("R7 run over limit flag", v, 8);
    for (int i = 0; i < 15; i++) cyc(3, 7, 4 + 4 * i, 1);
    rd(2, v); check("R4 sixteen-beat done", v, 1);

    // R4: open-ended burst closes on idle
    clr_all();
    cyc(2, 1, 0, 1); cyc(3, 1, 4, 1); cyc(3, 1, 8, 1); cyc(0, 0, 0, 1);
    rd(2, v); check("R4 open-ended done", v, 1);
    rd(4, v); check("R6 open-ended idle not abandon", v, 0);

    // R10: saturation
    clr_all();
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0);
    rd(1, v); check("R10 wait saturates", v, CMAXV);

    // R11: selective clears and priority
    cyc(1, 0, 0, 1);
    rd(4, v); check("R11 flag before clear", v, 1);
    step(0, 0, 0, 0, 1, 2);
    rd(4, v); check("R11 flags cleared", v, 0);
    rd(1, v); check("R11 counters kept", v, CMAXV);
    step(1, 0, 0, 0, 1, 1);
    rd(1, v); check("R11 clear beats increment", v, 0);
    rd(4, v); check("R11 flag set survives counter clear", v, 1);
    cyc(0, 0, 0, 1);
    rd(4, v); check("R11 flag sticky", v, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule